// File: doc/BRIEF.md
# SDRAM Mode Register and Burst Sequencer

This block holds the operating mode of a synchronous DRAM controller and uses it to sequence the column side of read and write bursts. A load strobe captures a 15-bit mode word taken from the two bank-address bits and the thirteen row/column address bits. The block checks the word and decodes four settings from it: burst length, address ordering, CAS latency and write mode. A word that uses a reserved or test encoding is refused. The block then reports an error and keeps its previous settings.

When a read or write command arrives with a start column, the block issues one column address per beat for the programmed burst length. Write beats are marked by a write enable. Read bursts produce a data-valid strobe that follows the command by the programmed CAS latency. A new command cuts short the burst in progress. Refresh, activation, precharge, physical I/O and the memory array belong elsewhere.

Top module: `sdr_mode_sequencer`

## Requirements
- R1: After reset the settings are 1 beat, sequential order, latency 2 and burst writes, `unconfigured` is 1, and `col_valid`, `wr_en`, `rd_valid` and `cfg_error` are 0. `unconfigured` drops only on the first accepted load and never rises again without reset.
- R2: A load is accepted only if all of these hold: `mode_word[14:9]` is 0, bit 7 is 0, bit 2 is 0, and bits 6:4 are 010 (latency 2) or 011 (latency 3). On acceptance the settings take effect in the cycle after the load. Bits 1:0 give the burst length (00 gives 1, 01 gives 2, 10 gives 4, 11 gives 8). Bit 3 selects interleaved order when set. Bit 8 selects single-beat writes when set.
- R3: A refused load raises `cfg_error` for exactly the one cycle after the load and leaves all settings and `unconfigured` unchanged.
- R4: In sequential order, beat k carries the start column with its low log2(BL) bits replaced by (start + k) mod BL. The upper bits are unchanged.
- R5: In interleaved order, beat k carries the start column with its low log2(BL) bits XORed with k. The upper bits are unchanged.
- R6: A command sampled at a clock edge drives `col_valid` high for BL consecutive cycles, starting in the cycle after that edge. If read and write are both asserted, the read wins.
- R7: `wr_en` is high on every beat of a write burst. In single-write mode a write has exactly one beat at the start column, while reads still run the full burst length.
- R8: For a read asserted in cycle c, `rd_valid` is high in cycles c+CL through c+CL+BL-1.
- R9: A command that arrives during a burst ends that burst at once, and the new burst's first beat follows in the next cycle. Read beats issued before the cut still produce their `rd_valid` cycles.
- R10: A read or write command asserted in the same cycle as `load_mode` is ignored and starts no burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| load_mode | input | 1 | Load the mode word this cycle |
| mode_word | input | 15 | {BA1, BA0, A12..A0} captured on a load |
| cmd_rd | input | 1 | Read command |
| cmd_wr | input | 1 | Write command |
| start_col | input | COL_W | Start column of the command |
| col_out | output | COL_W | Column address of the current beat |
| col_valid | output | 1 | A beat is being issued |
| wr_en | output | 1 | Current beat is a write |
| rd_valid | output | 1 | Read data expected this cycle |
| cfg_beats | output | 4 | Programmed burst length in beats |
| cfg_interleave | output | 1 | Interleaved ordering selected |
| cfg_cas | output | 2 | Programmed CAS latency |
| cfg_single_write | output | 1 | Single-beat write mode selected |
| unconfigured | output | 1 | No valid load since reset |
| cfg_error | output | 1 | Previous cycle's load was refused |

## Verification
A corrupted setting shows up in the cycle after the load that caused it, because the settings are driven straight from the register onto the `cfg_*` ports. A wrong beat counter or captured base appears as a wrong `col_out` or as a `col_valid` window of the wrong length within the burst itself. A fault in the latency pipeline or the read-beat marking shifts or drops `rd_valid` by one or two cycles. It becomes visible no later than CL cycles after the read. The reference model compares every output on every clock, so each of these faults is caught in the first cycle it diverges.

// File: rtl/sdr_mode_pkg.sv
package sdr_mode_pkg;

   localparam int MODE_W     = 15;
   localparam int BL_LSB     = 0;
   localparam int BT_BIT     = 3;
   localparam int CL_LSB     = 4;
   localparam int TEST_BIT   = 7;
   localparam int WM_BIT     = 8;
   localparam int RSV_LSB    = 9;
   localparam int MAX_BL_LOG = 3;   // longest burst is 8 beats
   localparam int MIN_CL     = 2;
   localparam int MAX_CL     = 3;

   typedef struct packed {
      logic [1:0] bl_log;      // log2 of burst length
      logic       interleave;
      logic       cas3;        // 1: latency 3, 0: latency 2
      logic       single_wr;
   } sdr_cfg_t;

   localparam sdr_cfg_t CFG_DEFAULT = '{bl_log: 2'd0, interleave: 1'b0,
                                        cas3: 1'b0, single_wr: 1'b0};

   function automatic logic mode_word_ok(input logic [MODE_W-1:0] w);
      logic [2:0] cl;
      cl = w[CL_LSB +: 3];
      return (w[MODE_W-1:RSV_LSB] == '0) && !w[TEST_BIT] && !w[BL_LSB+2] &&
             ((cl == 3'b010) || (cl == 3'b011));
   endfunction

   function automatic sdr_cfg_t mode_word_decode(input logic [MODE_W-1:0] w);
      sdr_cfg_t c;
      c.bl_log     = w[BL_LSB +: 2];
      c.interleave = w[BT_BIT];
      c.cas3       = w[CL_LSB];
      c.single_wr  = w[WM_BIT];
      return c;
   endfunction

endpackage

// File: rtl/sdr_mode_reg.sv
module sdr_mode_reg
   import sdr_mode_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_mode,
   input  logic [MODE_W-1:0] mode_word,
   output sdr_cfg_t          cfg,
   output logic              unconfigured,
   output logic              cfg_error
);

   logic word_ok;
   assign word_ok = mode_word_ok(mode_word);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg          <= CFG_DEFAULT;
         unconfigured <= 1'b1;
         cfg_error    <= 1'b0;
      end else begin
         cfg_error <= load_mode && !word_ok;
         if (load_mode && word_ok) begin
            cfg          <= mode_word_decode(mode_word);
            unconfigured <= 1'b0;
         end
      end
   end

endmodule

// File: rtl/sdr_burst_ctrl.sv
module sdr_burst_ctrl
   import sdr_mode_pkg::*;
#(
   parameter int COL_W = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cmd_rd,
   input  logic             cmd_wr,
   input  logic             cmd_block,
   input  logic [COL_W-1:0] start_col,
   input  sdr_cfg_t         cfg,
   output logic [COL_W-1:0] col_out,
   output logic             col_valid,
   output logic             wr_en,
   output logic             read_beat
);

   localparam int LOW_W = MAX_BL_LOG;

   if (COL_W < LOW_W) begin : g_bad_width
      $error("sdr_burst_ctrl: COL_W must cover the burst span");
   end

   logic             active_q;
   logic             is_rd_q;
   logic             ilv_q;
   logic [1:0]       span_q;      // log2 of beats actually run
   logic [LOW_W-1:0] beat_q;
   logic [LOW_W-1:0] last_q;
   logic [COL_W-1:0] base_q;

   logic             go;
   logic [1:0]       span_new;
   logic [LOW_W-1:0] seq_low;
   logic [LOW_W-1:0] ilv_low;
   logic [LOW_W-1:0] pick_low;

   assign go       = (cmd_rd || cmd_wr) && !cmd_block;
   assign span_new = (!cmd_rd && cfg.single_wr) ? 2'd0 : cfg.bl_log;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active_q <= 1'b0;
         is_rd_q  <= 1'b0;
         ilv_q    <= 1'b0;
         span_q   <= 2'd0;
         beat_q   <= '0;
         last_q   <= '0;
         base_q   <= '0;
      end else if (go) begin
         active_q <= 1'b1;
         is_rd_q  <= cmd_rd;
         ilv_q    <= cfg.interleave;
         span_q   <= span_new;
         beat_q   <= '0;
         last_q   <= LOW_W'((4'd1 << span_new) - 4'd1);
         base_q   <= start_col;
      end else if (active_q) begin
         if (beat_q == last_q) active_q <= 1'b0;
         else                  beat_q   <= beat_q + 1'b1;
      end
   end

   assign seq_low  = base_q[LOW_W-1:0] + beat_q;
   assign ilv_low  = base_q[LOW_W-1:0] ^ beat_q;
   assign pick_low = ilv_q ? ilv_low : seq_low;

   for (genvar i = 0; i < LOW_W; i++) begin : g_low
      assign col_out[i] = (span_q > 2'(i)) ? pick_low[i] : base_q[i];
   end

   if (COL_W > LOW_W) begin : g_high
      assign col_out[COL_W-1:LOW_W] = base_q[COL_W-1:LOW_W];
   end

   assign col_valid = active_q;
   assign wr_en     = active_q && !is_rd_q;
   assign read_beat = active_q && is_rd_q;

endmodule

// File: rtl/sdr_rdvalid_pipe.sv
module sdr_rdvalid_pipe
   import sdr_mode_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic beat_in,
   input  logic cas3,
   output logic rd_valid
);

   localparam int DEPTH = MAX_CL - 1;

   if (DEPTH < 2) begin : g_bad_depth
      $error("sdr_rdvalid_pipe: latency range needs at least two stages");
   end

   logic [DEPTH-1:0] stage_q;
   logic [1:0]       tap;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q <= '0;
      else        stage_q <= {stage_q[DEPTH-2:0], beat_in};
   end

   // latency L: beat issued one cycle after the command, so delay L-1
   assign tap      = cas3 ? 2'(MAX_CL - MIN_CL) : 2'd0;
   assign rd_valid = stage_q[tap];

endmodule

// File: rtl/sdr_mode_sequencer.sv
module sdr_mode_sequencer
   import sdr_mode_pkg::*;
#(
   parameter int COL_W = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_mode,
   input  logic [14:0]      mode_word,
   input  logic             cmd_rd,
   input  logic             cmd_wr,
   input  logic [COL_W-1:0] start_col,
   output logic [COL_W-1:0] col_out,
   output logic             col_valid,
   output logic             wr_en,
   output logic             rd_valid,
   output logic [3:0]       cfg_beats,
   output logic             cfg_interleave,
   output logic [1:0]       cfg_cas,
   output logic             cfg_single_write,
   output logic             unconfigured,
   output logic             cfg_error
);

   sdr_cfg_t cfg;
   logic     read_beat;

   sdr_mode_reg u_reg (
      .clk          (clk),
      .rst_n        (rst_n),
      .load_mode    (load_mode),
      .mode_word    (mode_word),
      .cfg          (cfg),
      .unconfigured (unconfigured),
      .cfg_error    (cfg_error)
   );

   sdr_burst_ctrl #(.COL_W(COL_W)) u_burst (
      .clk       (clk),
      .rst_n     (rst_n),
      .cmd_rd    (cmd_rd),
      .cmd_wr    (cmd_wr),
      .cmd_block (load_mode),
      .start_col (start_col),
      .cfg       (cfg),
      .col_out   (col_out),
      .col_valid (col_valid),
      .wr_en     (wr_en),
      .read_beat (read_beat)
   );

   sdr_rdvalid_pipe u_rdv (
      .clk      (clk),
      .rst_n    (rst_n),
      .beat_in  (read_beat),
      .cas3     (cfg.cas3),
      .rd_valid (rd_valid)
   );

   assign cfg_beats        = 4'd1 << cfg.bl_log;
   assign cfg_interleave   = cfg.interleave;
   assign cfg_cas          = cfg.cas3 ? 2'd3 : 2'd2;
   assign cfg_single_write = cfg.single_wr;

endmodule

// File: rtl/sdr_mode_sequencer_chk.sv
module sdr_mode_sequencer_chk #(
   parameter int COL_W = 10
) (
   input logic             clk,
   input logic             rst_n,
   input logic             load_mode,
   input logic             cmd_rd,
   input logic             cmd_wr,
   input logic [COL_W-1:0] col_out,
   input logic             col_valid,
   input logic             wr_en,
   input logic             rd_valid,
   input logic [3:0]       cfg_beats,
   input logic             cfg_interleave,
   input logic [1:0]       cfg_cas,
   input logic             cfg_single_write,
   input logic             unconfigured,
   input logic             cfg_error
);

   a_r1_unconf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      !unconfigured |=> !unconfigured);

   a_r2_clear_on_good_load: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(unconfigured) |-> (!cfg_error && $past(load_mode)));

   a_r3_error_follows_load: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_error |-> $past(load_mode));

   a_r3_reject_keeps_cfg: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_error |-> (cfg_beats == $past(cfg_beats) && cfg_cas == $past(cfg_cas) &&
                     cfg_interleave == $past(cfg_interleave) &&
                     cfg_single_write == $past(cfg_single_write) &&
                     unconfigured == $past(unconfigured)));

   a_r7_write_has_column: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> col_valid);

   a_r8_rdv_after_beat: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |-> ($past(col_valid) || $past(col_valid, 2)));

   a_r10_load_blocks_cmd: assert property (@(posedge clk) disable iff (!rst_n)
      (load_mode && (cmd_rd || cmd_wr) && !col_valid) |=> !col_valid);

   if (COL_W > 3) begin : g_upper
      a_r4_upper_bits_hold: assert property (@(posedge clk) disable iff (!rst_n)
         (col_valid && $past(col_valid) && !$past(cmd_rd || cmd_wr))
            |-> $stable(col_out[COL_W-1:3]));
   end

endmodule

bind sdr_mode_sequencer sdr_mode_sequencer_chk #(.COL_W(COL_W)) u_chk (
   .clk              (clk),
   .rst_n            (rst_n),
   .load_mode        (load_mode),
   .cmd_rd           (cmd_rd),
   .cmd_wr           (cmd_wr),
   .col_out          (col_out),
   .col_valid        (col_valid),
   .wr_en            (wr_en),
   .rd_valid         (rd_valid),
   .cfg_beats        (cfg_beats),
   .cfg_interleave   (cfg_interleave),
   .cfg_cas          (cfg_cas),
   .cfg_single_write (cfg_single_write),
   .unconfigured     (unconfigured),
   .cfg_error        (cfg_error)
);

// File: tb/sdr_mode_sequencer_test.sv
`timescale 1ns/1ps
module sdr_mode_sequencer_test;

   localparam int COL_W = 10;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             load_mode = 1'b0;
   logic [14:0]      mode_word = '0;
   logic             cmd_rd = 1'b0;
   logic             cmd_wr = 1'b0;
   logic [COL_W-1:0] start_col = '0;
   logic [COL_W-1:0] col_out;
   logic             col_valid, wr_en, rd_valid;
   logic [3:0]       cfg_beats;
   logic             cfg_interleave;
   logic [1:0]       cfg_cas;
   logic             cfg_single_write, unconfigured, cfg_error;

   always #2 clk = ~clk;   // 250 MHz

   sdr_mode_sequencer #(.COL_W(COL_W)) uut (.*);

   int    n_cmp = 0;
   int    n_bad = 0;
   bit    started = 0;
   bit    finished = 0;
   string phase = "R1";

   // reference model state
   int m_beats = 1, m_ilv = 0, m_cas = 2, m_single = 0, m_unconf = 1, m_err = 0;
   int b_act = 0, b_beat = 0, b_len = 1, b_base = 0, b_ilv = 0, b_rd = 0;
   int h1 = 0, h2 = 0;

   function automatic bit legal(int w);
      int cl;
      cl = (w >> 4) & 7;
      if ((w >> 9) != 0) return 0;
      if (((w >> 7) & 1) != 0) return 0;
      if ((w & 3'b111) > 3) return 0;
      return (cl == 2) || (cl == 3);
   endfunction

   always @(posedge clk) begin
      started <= 1;
      if (!rst_n) begin
         m_beats = 1; m_ilv = 0; m_cas = 2; m_single = 0; m_unconf = 1; m_err = 0;
         b_act = 0; b_beat = 0; b_len = 1; h1 = 0; h2 = 0;
      end else begin
         h2 = h1;
         h1 = (b_act != 0 && b_rd != 0) ? 1 : 0;
         if ((cmd_rd || cmd_wr) && !load_mode) begin
            b_act = 1; b_beat = 0; b_base = int'(start_col); b_ilv = m_ilv;
            b_rd = cmd_rd ? 1 : 0;
            b_len = (!cmd_rd && m_single != 0) ? 1 : m_beats;
         end else if (b_act != 0) begin
            if (b_beat == b_len - 1) b_act = 0;
            else b_beat++;
         end
         m_err = 0;
         if (load_mode) begin
            if (legal(int'(mode_word))) begin
               m_beats  = 1 << (mode_word & 15'd3);
               m_ilv    = mode_word[3];
               m_cas    = int'(mode_word[6:4]);
               m_single = mode_word[8];
               m_unconf = 0;
            end else m_err = 1;
         end
      end
   end

   task automatic chk(string req, string sig, int got, int exp);
      n_cmp++;
      if (got != exp) begin
         n_bad++;
         $display("FAIL %s [%s] %s: got %0h expected %0h", req, phase, sig, got, exp);
      end
   endtask

   always @(negedge clk) begin
      if (started && !finished) begin
         int mask, ecol;
         mask = b_len - 1;
         ecol = b_ilv ? ((b_base & ~mask) | ((b_base ^ b_beat) & mask))
                      : ((b_base & ~mask) | ((b_base + b_beat) & mask));
         chk("R1", "unconfigured", unconfigured, m_unconf);
         chk("R3", "cfg_error", cfg_error, m_err);
         chk("R2", "cfg_beats", cfg_beats, m_beats);
         chk("R2", "cfg_interleave", cfg_interleave, m_ilv);
         chk("R2", "cfg_cas", cfg_cas, m_cas);
         chk("R2", "cfg_single_write", cfg_single_write, m_single);
         chk("R6", "col_valid", col_valid, b_act);
         chk("R7", "wr_en", wr_en, (b_act != 0 && b_rd == 0) ? 1 : 0);
         chk("R8", "rd_valid", rd_valid, (m_cas == 3) ? h2 : h1);
         if (b_act != 0)
            chk(b_ilv ? "R5" : "R4", "col_out", int'(col_out), ecol);
      end
   end

   task automatic step(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic load(int w);
      load_mode = 1'b1; mode_word = 15'(w);
      step(1);
      load_mode = 1'b0; mode_word = '0;
      step(1);
   endtask

   task automatic cmd(bit rd, bit wr, int col);
      cmd_rd = rd; cmd_wr = wr; start_col = COL_W'(col);
      step(1);
      cmd_rd = 1'b0; cmd_wr = 1'b0;
   endtask

   task automatic finish_run();
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_cmp++; n_bad++;
      $display("FAIL R6 watchdog: got timeout expected completion");
      finish_run();
   end

   initial begin
      step(3);
      rst_n = 1'b1;
      step(2);
      phase = "R1";
      cmd(1, 0, 'h155); step(5);
      cmd(0, 1, 'h2AA); step(4);

      phase = "R4";
      load('h032);                       // BL4, sequential, CL3
      cmd(1, 0, 'h1A5); step(8);
      cmd(0, 1, 'h1A7); step(6);

      phase = "R5";
      load('h02B);                       // BL8, interleaved, CL2
      cmd(1, 0, 'h0F3); step(12);
      cmd(0, 1, 'h3FE); step(10);

      phase = "R2";
      for (int bl = 0; bl < 4; bl++)
         for (int bt = 0; bt < 2; bt++)
            for (int cl = 2; cl < 4; cl++) begin
               load((cl << 4) | (bt << 3) | bl);
               cmd(1, 0, int'($urandom) & 'h3FF); step(12);
               cmd(0, 1, int'($urandom) & 'h3FF); step(10);
            end

      phase = "R7";
      load('h133);                       // BL8, sequential, CL3, single write
      cmd(0, 1, 'h0C6); step(4);
      cmd(1, 0, 'h0C6); step(12);
      cmd(1, 1, 'h011); step(12);       // read wins

      phase = "R3";
      load('h4032); step(1);             // bank bit set
      load('h00B2); step(1);             // test bit set
      load('h0034); step(1);             // burst code 100
      load('h0012); step(1);             // latency code 001
      load('h0042); step(1);             // latency code 100
      load('h0232); step(1);             // A9 set
      cmd(1, 0, 'h2B5); step(12);

      phase = "R9";
      load('h023);                       // BL8, sequential, CL2
      cmd(1, 0, 'h100); step(2);
      cmd(0, 1, 'h208); step(1);
      cmd(1, 0, 'h30F); step(3);
      load('h0033);                      // CL3 while reads drain
      cmd(1, 0, 'h044); cmd(0, 1, 'h055); step(12);

      phase = "R10";
      load_mode = 1'b1; mode_word = 15'h022; cmd_rd = 1'b1; start_col = 'h111;
      step(1);
      load_mode = 1'b0; cmd_rd = 1'b0; mode_word = '0;
      step(3);
      cmd(0, 1, 'h1F0); step(1);
      load_mode = 1'b1; mode_word = 15'h0032; cmd_wr = 1'b1;
      step(1);
      load_mode = 1'b0; cmd_wr = 1'b0;
      step(10);

      finish_run();
   end

endmodule